// File: doc/BRIEF.md
# Channel Status Block Sequencer

This block feeds the channel-status bit of a serial digital audio transmitter. A 192-bit status block is supplied as six 32-bit words on one wide input. The sequencer loads the words one at a time into an internal shifter and gives out one bit per frame strobe from the framer. It also raises a block-start flag on the frame that carries the first bit of the block, so that the framer can insert the block-start preamble there.

Sequencing begins once the transmitter enable and the channel-status enable are both high. After the last bit of the sixth word the sequence returns to the first word if both enables are still high, and goes idle if they are not. Dropping the transmitter enable stops the sequence at the next end-of-frame indication. A busy flag shows that the block is still in progress. It rises when the first word is loaded and falls when the sixth word is loaded or when the sequence stops. Biphase coding and preamble generation belong to the framer.

Top module: `cs_block_seq`

## Requirements
- R1: During reset and right after it, `busy`, `blk_start` and `cs_bit` are 0.
- R2: While idle, the sequence starts only when `tx_en` and `cs_en` are both high. The clock edge after both are seen high loads word 0 (`status_words[31:0]`) and sets `busy`. With only `tx_en` high, no start occurs.
- R3: Word k occupies `status_words[32k+31:32k]`, and the words are sent in order 0 to 5. Each word goes out least-significant bit first. `cs_bit` shows the current bit during a cycle with `frame_stb` high, and the sequence advances one bit on that clock edge.
- R4: `blk_start` is 1 exactly while the bit on offer is bit 0 of word 0. It is not gated by `cs_en`.
- R5: `busy` falls on the edge that loads word 5, which is the edge of the strobe that consumes bit 31 of word 4.
- R6: On the strobe that consumes bit 31 of word 5, the sequence wraps to word 0 and `busy` rises again if `tx_en` and `cs_en` are both high. Otherwise the block goes idle and stays with `busy` at 0.
- R7: While `cs_en` is low, `cs_bit` is 0, yet the bit position keeps advancing on each strobe.
- R8: If `frame_end` is high while `tx_en` is low, the sequence stops at that edge. `busy` goes to 0, the block goes idle, and a strobe in the same cycle does not advance it. `frame_end` with `tx_en` high has no effect. `tx_en` low without `frame_end` does not stop the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable |
| cs_en | input | 1 | Channel-status enable |
| frame_stb | input | 1 | One pulse per frame; consumes the bit on offer |
| frame_end | input | 1 | End-of-frame indication for stopping |
| status_words | input | 192 | Six status words, word k at bits 32k+31:32k |
| cs_bit | output | 1 | Channel-status bit for the current frame |
| blk_start | output | 1 | Current bit is the first bit of the block |
| busy | output | 1 | Block transmission in progress |

## Verification
Two events can fall on the same edge: a strobe that would advance the shifter, and an end-of-frame stop while `tx_en` is low. The bench raises `frame_stb` and `frame_end` together in the middle of word 1. It expects the bit on offer to be delivered in that cycle, and then expects `busy` and `blk_start` to be 0 and `cs_bit` to stay 0 on later strobes. A restart must then begin again at bit 0 of word 0, which shows that the coincident strobe left no trace. The bench also sets the word-5 wrap decision against a low `cs_en` and checks that the block goes idle rather than wrapping.

// File: rtl/cssq_pkg.sv
package cssq_pkg;
  // total status bits in one block
  function automatic int unsigned block_bits(input int unsigned word_w,
                                             input int unsigned n_words);
    return word_w * n_words;
  endfunction

  // index of the word whose load ends the busy window
  function automatic int unsigned busy_end_word(input int unsigned n_words);
    return (n_words > 0) ? n_words - 1 : 0;
  endfunction
endpackage

// File: rtl/cssq_word_mux.sv
module cssq_word_mux #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 6,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic [WORD_W*N_WORDS-1:0] words,
  input  logic [IDX_W-1:0]          sel,
  output logic [WORD_W-1:0]         word
);
  logic [WORD_W-1:0] slot [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_slot
    assign slot[g] = words[g*WORD_W +: WORD_W];
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < N_WORDS; i++)
      if (sel == IDX_W'(i)) word = slot[i];
  end
endmodule

// File: rtl/cssq_shift.sv
module cssq_shift #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              adv_en,
  input  logic [WORD_W-1:0] load_word,
  output logic              lsb
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (load_en) sh_q <= load_word;
    else if (adv_en)  sh_q <= {1'b0, sh_q[WORD_W-1:1]};
  end

  assign lsb = sh_q[0];
endmodule

// File: rtl/cssq_ctrl.sv
module cssq_ctrl
  import cssq_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 6,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1,
  localparam int F_IDX  = busy_end_word(N_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             cs_en,
  input  logic             frame_stb,
  input  logic             frame_end,
  output logic             active,
  output logic             busy,
  output logic             blk_start,
  output logic             load_en,
  output logic             adv_en,
  output logic [IDX_W-1:0] load_idx,
  output logic             load_a_ev,
  output logic             load_f_ev,
  output logic             stop_ev,
  output logic             end_ev
);
  logic [IDX_W-1:0] word_q;
  logic [BIT_W-1:0] bit_q;
  logic             start_ev, word_done, last_word, step_ev, wrap_ev;

  assign start_ev  = !active && tx_en && cs_en;
  assign stop_ev   = active && !tx_en && frame_end;
  assign adv_en    = active && frame_stb && !stop_ev;
  assign word_done = adv_en && (bit_q == BIT_W'(WORD_W - 1));
  assign last_word = (word_q == IDX_W'(N_WORDS - 1));
  assign step_ev   = word_done && !last_word;
  assign wrap_ev   = word_done && last_word && tx_en && cs_en;
  assign end_ev    = word_done && last_word && !(tx_en && cs_en);
  assign load_a_ev = start_ev || wrap_ev;
  assign load_f_ev = step_ev && (word_q + IDX_W'(1) == IDX_W'(F_IDX));
  assign load_en   = load_a_ev || step_ev;
  assign load_idx  = load_a_ev ? '0 : word_q + IDX_W'(1);
  assign blk_start = active && (word_q == '0) && (bit_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      busy   <= 1'b0;
      word_q <= '0;
      bit_q  <= '0;
    end else begin
      if (stop_ev || end_ev)  active <= 1'b0;
      else if (load_a_ev)     active <= 1'b1;

      if (stop_ev || end_ev || load_f_ev) busy <= 1'b0;
      else if (load_a_ev)                 busy <= 1'b1;

      if (load_en) begin
        word_q <= load_idx;
        bit_q  <= '0;
      end else if (adv_en) begin
        bit_q  <= bit_q + BIT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cs_block_seq.sv
module cs_block_seq #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 6,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int BLK_W  = WORD_W * N_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             cs_en,
  input  logic             frame_stb,
  input  logic             frame_end,
  input  logic [BLK_W-1:0] status_words,
  output logic             cs_bit,
  output logic             blk_start,
  output logic             busy
);
  logic             active, load_en, adv_en;
  logic             load_a_ev, load_f_ev, stop_ev, end_ev, sh_lsb;
  logic [IDX_W-1:0] load_idx;
  logic [WORD_W-1:0] next_word;

  cssq_ctrl #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cs_en(cs_en),
    .frame_stb(frame_stb), .frame_end(frame_end),
    .active(active), .busy(busy), .blk_start(blk_start),
    .load_en(load_en), .adv_en(adv_en), .load_idx(load_idx),
    .load_a_ev(load_a_ev), .load_f_ev(load_f_ev),
    .stop_ev(stop_ev), .end_ev(end_ev)
  );

  cssq_word_mux #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_mux (
    .words(status_words), .sel(load_idx), .word(next_word)
  );

  cssq_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .adv_en(adv_en),
    .load_word(next_word), .lsb(sh_lsb)
  );

  assign cs_bit = active && cs_en && sh_lsb;
endmodule

// File: rtl/cssq_checker.sv
module cssq_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic cs_en,
  input logic frame_end,
  input logic cs_bit,
  input logic blk_start,
  input logic busy,
  input logic active,
  input logic load_a_ev,
  input logic load_f_ev,
  input logic stop_ev,
  input logic end_ev
);
  // R2: idle with both enables high starts the block
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && tx_en && cs_en) |=> (busy && blk_start));

  // R2: busy only rises through a word-0 load
  a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load_a_ev));

  // R5, R8: busy only falls on word-5 load, stop or end
  a_r5_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(load_f_ev || stop_ev || end_ev));

  // R4: block start is only flagged while the block runs
  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |-> busy);

  // R7: status bit quiet when channel status disabled
  a_r7_bit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_en |-> !cs_bit);

  // R8: frame-aligned stop leaves the block idle
  a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tx_en && frame_end) |=> (!busy && !blk_start && !cs_bit));
endmodule

bind cs_block_seq cssq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cs_en(cs_en),
  .frame_end(frame_end), .cs_bit(cs_bit), .blk_start(blk_start),
  .busy(busy), .active(active), .load_a_ev(load_a_ev),
  .load_f_ev(load_f_ev), .stop_ev(stop_ev), .end_ev(end_ev)
);

// File: tb/cs_block_seq_bench.sv
module cs_block_seq_bench;
  localparam int NW = 6;
  localparam int WW = 32;
  localparam int NB = NW * WW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, cs_en = 1'b0, frame_stb = 1'b0, frame_end = 1'b0;
  logic [NB-1:0] status_words;
  logic cs_bit, blk_start, busy;

  int total = 0, bad = 0;
  bit done = 0;
  int k = 0;        // bench position in the block
  bit idle = 1;
  logic [1:0] sb_q[$]; // {blk_start, cs_bit} expected per strobe

  always #4 clk = ~clk;

  cs_block_seq u_cs_block_seq (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cs_en(cs_en),
    .frame_stb(frame_stb), .frame_end(frame_end),
    .status_words(status_words), .cs_bit(cs_bit),
    .blk_start(blk_start), .busy(busy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compare each strobe against the scoreboard
  always @(negedge clk) begin
    if (rst_n && frame_stb) begin
      if (sb_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3: strobe with empty scoreboard got %0b expected item", cs_bit);
      end else begin
        logic [1:0] e;
        e = sb_q.pop_front();
        chk("R3/R7 cs_bit", cs_bit, e[0]);
        chk("R4 blk_start", blk_start, e[1]);
      end
    end
  end

  // driver: one frame, optionally coinciding with end-of-frame
  task automatic frame(input bit with_end);
    logic eb;
    eb = (!idle && cs_en) ? status_words[k] : 1'b0;
    sb_q.push_back({(!idle && k == 0), eb});
    @(posedge clk); #1;
    frame_stb = 1'b1;
    frame_end = with_end;
    @(posedge clk); #1;
    frame_stb = 1'b0;
    frame_end = 1'b0;
    if (!idle) begin
      if (with_end && !tx_en) idle = 1;
      else if (k == NB - 1) begin
        if (tx_en && cs_en) k = 0; else idle = 1;
      end else k++;
    end
    @(negedge clk);
    chk("R5/R6/R8 busy", busy, (!idle && k < NB - WW));
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) frame(1'b0);
  endtask

  // raise both enables from idle and confirm start timing
  task automatic start_block();
    @(posedge clk); #1;
    tx_en = 1'b1; cs_en = 1'b1;
    @(negedge clk);
    chk("R2 busy before edge", busy, 1'b0);
    @(negedge clk);
    chk("R2 busy after start", busy, 1'b1);
    chk("R2 blk_start after start", blk_start, 1'b1);
    idle = 0; k = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    status_words = {32'h6D1E_B7C4, 32'h0F0F_33CC, 32'hFFFF_0001,
                    32'h8000_0000, 32'h1234_ABCD, 32'hA5C3_0F81};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy in reset", busy, 1'b0);
    chk("R1 blk_start in reset", blk_start, 1'b0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 1'b0);
    chk("R1 cs_bit after reset", cs_bit, 1'b0);

    // R2: transmitter enable alone does not start
    @(posedge clk); #1 tx_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 no start on tx_en only", busy, 1'b0);
    frame(1'b0);

    // R3, R4, R5, R6: full block then wrap
    start_block();
    frames(NB);
    chk("R6 wrapped to word 0", blk_start, 1'b1);

    // R8: frame_end with tx_en high has no effect
    @(posedge clk); #1 frame_end = 1'b1;
    @(posedge clk); #1 frame_end = 1'b0;
    @(negedge clk);
    chk("R8 frame_end ignored busy", busy, 1'b1);
    chk("R8 frame_end ignored blk", blk_start, 1'b1);

    // R7: cs_en low silences bits but position advances
    @(posedge clk); #1 cs_en = 1'b0;
    frames(40);
    @(posedge clk); #1 cs_en = 1'b1;
    frames(NB - 1 - 40);
    // R6: cs_en low at the wrap decision leads to idle
    @(posedge clk); #1 cs_en = 1'b0;
    frame(1'b0);
    frames(3);
    chk("R6 idle keeps blk_start low", blk_start, 1'b0);

    start_block();
    frames(50);
    // R8: tx_en low alone does not stop
    @(posedge clk); #1 tx_en = 1'b0;
    frames(2);
    // R8: stop wins over a coincident strobe
    frame(1'b1);
    frames(2);
    chk("R8 stopped blk_start", blk_start, 1'b0);
    // restart must begin at word 0 bit 0
    @(posedge clk); #1 cs_en = 1'b0;
    start_block();
    frames(40);

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule